// File: doc/BRIEF.md
# Offset Trim Calibration Sequencer

This block runs the offset calibration of an amplifier whose rail-to-rail input stage has two independent differential pairs, one built from NMOS and one from PMOS devices. When software pulses a start input, the sequencer switches the amplifier on and moves it from factory trim to user trim. It then ties both amplifier inputs to an internal reference and searches for the trim code that cancels the offset.

The search goes upward one code at a time and starts at zero. After each new code it waits a fixed number of settle cycles and then reads the comparator status. It stops at the first code whose status reads 0. The NMOS pair is calibrated first, against the high reference. The PMOS pair follows, against the low reference. Both codes are kept as results. If a pass reaches the top code without a 0, it stores that top code and raises an error flag.

After the second pass the sequencer releases calibration mode and gives a one-cycle done pulse. It leaves the amplifier running on the codes it found.

Top module: `offset_cal_seq`

## Requirements
- R1: While reset is high, and after it, every output is 0. This includes the two trim codes, both results, `ref_sel_o` = 00, busy, done and error.
- R2: A start pulse sampled while idle starts a run. On the following cycle `amp_en_o`, `user_trim_o`, `cal_on_o` and `busy_o` are 1, `ref_sel_o` is 11, both trim codes are 0 and `err_o` is 0. `amp_en_o` and `user_trim_o` stay 1 from then on.
- R3: The first pass drives `ref_sel_o` = 11 (high reference), steps only `trim_n_o` and holds `trim_p_o` at 0. The second pass drives `ref_sel_o` = 01 (low reference), steps only `trim_p_o` and holds `trim_n_o` at the first pass's result.
- R4: Each sample that reads `cmp_i` = 1 below the top code raises the active trim code by exactly one. Within a run, a trim code never changes in any other way.
- R5: Every trim code, and every change of reference, is held for SETTLE_CYC cycles before `cmp_i` is sampled. A run whose passes stop at codes n and p takes exactly SETTLE_CYC*(n+p+2) cycles from the start edge to the done edge.
- R6: Each pass stores as its result the first code at which the sampled `cmp_i` is 0.
- R7: If `cmp_i` is still 1 when a pass samples code 31, that pass stores 31 and `err_o` goes to 1. `err_o` is cleared only when the next run starts.
- R8: `done_o` is high for exactly one cycle at the end of a run. In that cycle `cal_on_o` and `busy_o` are already 0.
- R9: After done, both trim codes and both results stay constant until the next start.
- R10: A start pulse during a run is ignored. The run's timing and results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to calibrate |
| cmp_i | input | 1 | Comparator status: 1 while the trim is still below the offset |
| amp_en_o | output | 1 | Amplifier enable |
| user_trim_o | output | 1 | Selects user trim codes instead of factory codes |
| cal_on_o | output | 1 | Ties both amplifier inputs to the internal reference |
| ref_sel_o | output | 2 | Reference select: 11 high reference, 01 low reference |
| trim_n_o | output | TRIM_W | NMOS pair trim code applied |
| trim_p_o | output | TRIM_W | PMOS pair trim code applied |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | A pass hit the top code without the status reading 0 |
| result_n_o | output | TRIM_W | Stored NMOS trim result |
| result_p_o | output | TRIM_W | Stored PMOS trim result |

## Verification
The bench models the comparator, and the model reads 1 until a code has been held for the full settle time. A sequencer that samples early therefore walks past the true threshold and stores a code that is too high. The bench sweeps each pair's threshold across every code from 0 to 32, with the other pair's threshold held fixed. A threshold of 0 shows whether the design tests code 0 before it increments. A threshold of 32 shows whether it saturates at 31 with an error, rather than wrapping to 0. The bench also checks the exact run length and that the NMOS code is held while the PMOS pass runs. It checks that an error from one run does not survive into the next, and that a start pulse sent during a run changes neither the cycle count nor the results.

// File: rtl/ocal_pkg.sv
package ocal_pkg;
  localparam int NUM_PASS = 2;
  localparam int PASS_N   = 0;
  localparam int PASS_P   = 1;

  localparam logic [1:0] REF_SEL_HI = 2'b11;
  localparam logic [1:0] REF_SEL_LO = 2'b01;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ocal_state_e;
endpackage

// File: rtl/ocal_settle_timer.sv
module ocal_settle_timer #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic settled_o
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load_i)       cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign settled_o = (cnt_q == '0);

  // R5: once expired, the counter must not wrap without a new load
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/ocal_trim_step.sv
module ocal_trim_step #(
  parameter int TRIM_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              inc_i,
  output logic [TRIM_W-1:0] code_o,
  output logic              at_max_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i)          code_o <= '0;
    else if (inc_i && !at_max_o) code_o <= code_o + 1'b1;
  end

  assign at_max_o = &code_o;

  // R4: outside a clear, the code only ever moves up by one
  p_step_by_one_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(clear_i) && code_o != $past(code_o)) |-> (code_o == $past(code_o) + 1'b1));
endmodule

// File: rtl/ocal_ctrl.sv
module ocal_ctrl
  import ocal_pkg::*;
#(
  parameter int TRIM_W = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start_i,
  input  logic                             cmp_i,
  input  logic                             settled_i,
  input  logic [NUM_PASS-1:0][TRIM_W-1:0]  code_i,
  input  logic [NUM_PASS-1:0]              at_max_i,
  output logic [NUM_PASS-1:0]              clear_o,
  output logic [NUM_PASS-1:0]              inc_o,
  output logic                             load_o,
  output logic                             amp_en_o,
  output logic                             user_trim_o,
  output logic                             cal_on_o,
  output logic [1:0]                       ref_sel_o,
  output logic                             busy_o,
  output logic                             done_o,
  output logic                             err_o,
  output logic [NUM_PASS-1:0][TRIM_W-1:0]  result_o
);
  ocal_state_e state_q;
  logic        pass_q;
  logic        fire;
  logic        hit;

  assign fire = (state_q == ST_WAIT) && settled_i;
  assign hit  = !cmp_i || at_max_i[pass_q];

  always_comb begin
    clear_o = '0;
    inc_o   = '0;
    load_o  = 1'b0;
    if (state_q == ST_IDLE && start_i) begin
      clear_o = '1;
      load_o  = 1'b1;
    end else if (fire) begin
      if (!hit) begin
        inc_o[pass_q] = 1'b1;
        load_o        = 1'b1;
      end else if (pass_q == 1'(PASS_N)) begin
        load_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      pass_q      <= 1'(PASS_N);
      amp_en_o    <= 1'b0;
      user_trim_o <= 1'b0;
      cal_on_o    <= 1'b0;
      ref_sel_o   <= 2'b00;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      result_o    <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q     <= ST_WAIT;
            pass_q      <= 1'(PASS_N);
            amp_en_o    <= 1'b1;
            user_trim_o <= 1'b1;
            cal_on_o    <= 1'b1;
            ref_sel_o   <= REF_SEL_HI;
            busy_o      <= 1'b1;
            err_o       <= 1'b0;
          end
        end
        default: begin
          if (fire && hit) begin
            result_o[pass_q] <= code_i[pass_q];
            err_o            <= err_o | cmp_i;
            if (pass_q == 1'(PASS_N)) begin
              pass_q    <= 1'(PASS_P);
              ref_sel_o <= REF_SEL_LO;
            end else begin
              state_q  <= ST_IDLE;
              cal_on_o <= 1'b0;
              busy_o   <= 1'b0;
              done_o   <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8: calibration mode is released by the time done is seen
  p_done_caloff_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!cal_on_o && !busy_o));
  // R7: an error at done implies a saturated result
  p_err_sat_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (&result_o[PASS_N] || &result_o[PASS_P]));
  // R3: a run only ever uses the two calibration references
  p_ref_legal_r3: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (ref_sel_o == REF_SEL_HI || ref_sel_o == REF_SEL_LO));
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
  import ocal_pkg::*;
#(
  parameter int TRIM_W     = 5,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cmp_i,
  output logic              amp_en_o,
  output logic              user_trim_o,
  output logic              cal_on_o,
  output logic [1:0]        ref_sel_o,
  output logic [TRIM_W-1:0] trim_n_o,
  output logic [TRIM_W-1:0] trim_p_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [TRIM_W-1:0] result_n_o,
  output logic [TRIM_W-1:0] result_p_o
);
  logic [NUM_PASS-1:0][TRIM_W-1:0] code;
  logic [NUM_PASS-1:0][TRIM_W-1:0] result;
  logic [NUM_PASS-1:0]             at_max;
  logic [NUM_PASS-1:0]             clear;
  logic [NUM_PASS-1:0]             inc;
  logic                            load;
  logic                            settled;

  ocal_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .settled_o (settled)
  );

  for (genvar g = 0; g < NUM_PASS; g++) begin : g_pair
    ocal_trim_step #(.TRIM_W(TRIM_W)) u_step (
      .clk      (clk),
      .rst      (rst),
      .clear_i  (clear[g]),
      .inc_i    (inc[g]),
      .code_o   (code[g]),
      .at_max_o (at_max[g])
    );
  end

  ocal_ctrl #(.TRIM_W(TRIM_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .cmp_i       (cmp_i),
    .settled_i   (settled),
    .code_i      (code),
    .at_max_i    (at_max),
    .clear_o     (clear),
    .inc_o       (inc),
    .load_o      (load),
    .amp_en_o    (amp_en_o),
    .user_trim_o (user_trim_o),
    .cal_on_o    (cal_on_o),
    .ref_sel_o   (ref_sel_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .result_o    (result)
  );

  assign trim_n_o   = code[PASS_N];
  assign trim_p_o   = code[PASS_P];
  assign result_n_o = result[PASS_N];
  assign result_p_o = result[PASS_P];

  // Hold-time observer for the settle check (assertion support only)
  localparam int HW = $clog2(SETTLE_CYC + 2);
  logic [2*TRIM_W+2:0] view, view_q;
  logic [HW-1:0]       held_q, held_now;

  assign view     = {cal_on_o, ref_sel_o, trim_n_o, trim_p_o};
  assign held_now = (view == view_q) ? held_q + 1'b1 : HW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      view_q <= '0;
      held_q <= '0;
    end else begin
      view_q <= view;
      held_q <= (held_now > HW'(SETTLE_CYC)) ? HW'(SETTLE_CYC) : held_now;
    end
  end

  // R5: the status is sampled only after the applied setting has settled
  p_settle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && settled) |-> (held_now >= HW'(SETTLE_CYC)));
  // R9: while idle with no start, codes and results are frozen
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> ($stable(trim_n_o) && $stable(trim_p_o) &&
                               $stable(result_n_o) && $stable(result_p_o)));
  // R3: the PMOS code is untouched during the high-reference pass
  p_pmos_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && ref_sel_o == REF_SEL_HI) |-> (trim_p_o == '0));
endmodule

// File: tb/tb_offset_cal_seq.sv
module tb_offset_cal_seq;
  localparam int TW     = 5;
  localparam int SETTLE = 3;
  localparam int TOP    = (1 << TW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic cmp_i = 1'b1;
  logic amp_en_o, user_trim_o, cal_on_o, busy_o, done_o, err_o;
  logic [1:0] ref_sel_o;
  logic [TW-1:0] trim_n_o, trim_p_o, result_n_o, result_p_o;

  int n_tests = 0;
  int n_fail  = 0;
  int thr_n = 0, thr_p = 0, exp_n = 0;
  int mon_bad = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  offset_cal_seq #(.TRIM_W(TW), .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .cmp_i(cmp_i),
    .amp_en_o(amp_en_o), .user_trim_o(user_trim_o), .cal_on_o(cal_on_o),
    .ref_sel_o(ref_sel_o), .trim_n_o(trim_n_o), .trim_p_o(trim_p_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .result_n_o(result_n_o), .result_p_o(result_p_o)
  );

  // Comparator model: reads 1 until the applied setting has been held SETTLE cycles
  logic [2*TW+2:0] last_view = '0;
  int age = 0;
  logic [TW-1:0] prev_n = '0, prev_p = '0;
  logic prev_busy = 1'b0;

  always @(negedge clk) begin
    logic [2*TW+2:0] v;
    v = {cal_on_o, ref_sel_o, trim_n_o, trim_p_o};
    if (v != last_view) age = 1;
    else if (age < 1000) age = age + 1;
    last_view = v;
    if (!cal_on_o || age < SETTLE) cmp_i = 1'b1;
    else if (ref_sel_o == 2'b11) cmp_i = (int'(trim_n_o) < thr_n);
    else if (ref_sel_o == 2'b01) cmp_i = (int'(trim_p_o) < thr_p);
    else cmp_i = 1'b1;
    // R2/R3/R4 run monitor
    if (busy_o) begin
      if (!amp_en_o || !user_trim_o) mon_bad++;
      if (ref_sel_o == 2'b11 && trim_p_o != '0) mon_bad++;
      if (ref_sel_o == 2'b01 && int'(trim_n_o) != exp_n) mon_bad++;
      if (ref_sel_o != 2'b11 && ref_sel_o != 2'b01) mon_bad++;
      if (prev_busy) begin
        if (trim_n_o != prev_n && trim_n_o != prev_n + 1'b1) mon_bad++;
        if (trim_p_o != prev_p && trim_p_o != prev_p + 1'b1) mon_bad++;
      end
    end
    prev_n = trim_n_o;
    prev_p = trim_p_o;
    prev_busy = busy_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic run_cal(input int tn, input int tp, input int inj);
    int rn, rp, cyc, exp_cyc;
    bit got, exp_err;
    logic [TW-1:0] hn, hp;
    thr_n = tn;
    thr_p = tp;
    rn = (tn > TOP) ? TOP : tn;
    rp = (tp > TOP) ? TOP : tp;
    exp_n = rn;
    exp_err = (tn > TOP) || (tp > TOP);
    exp_cyc = SETTLE * (rn + rp + 2);
    mon_bad = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
    // R2: state one cycle after start
    chk(amp_en_o && user_trim_o && cal_on_o && busy_o && !err_o,
        "R2 enables", {amp_en_o, user_trim_o, cal_on_o, busy_o, err_o}, 5'b11110);
    chk(ref_sel_o == 2'b11 && trim_n_o == '0 && trim_p_o == '0,
        "R2 initial codes", {ref_sel_o, trim_n_o, trim_p_o}, {2'b11, 10'd0});
    cyc = 0;
    got = 1'b0;
    while (!got && cyc < 20000) begin
      if (inj > 0 && cyc == inj) start_i = 1'b1;
      @(posedge clk);
      #1 start_i = 1'b0;
      cyc++;
      if (done_o) got = 1'b1;
    end
    chk(got, "R8 done seen", int'(got), 1);
    chk(cyc == exp_cyc, (inj > 0) ? "R10 run length with extra start" : "R5 run length",
        cyc, exp_cyc);
    chk(int'(result_n_o) == rn, "R6 nmos result", int'(result_n_o), rn);
    chk(int'(result_p_o) == rp, "R6 pmos result", int'(result_p_o), rp);
    chk(err_o == exp_err, "R7 error flag", int'(err_o), int'(exp_err));
    chk(!cal_on_o && !busy_o, "R8 cal off at done", {cal_on_o, busy_o}, 0);
    chk(int'(trim_n_o) == rn && int'(trim_p_o) == rp, "R9 applied codes",
        {trim_n_o, trim_p_o}, (rn << TW) | rp);
    chk(mon_bad == 0, "R3 R4 pass sequencing", mon_bad, 0);
    hn = result_n_o;
    hp = result_p_o;
    @(posedge clk);
    #1 chk(!done_o, "R8 done single cycle", int'(done_o), 0);
    repeat (4) @(posedge clk);
    #1;
    chk(result_n_o == hn && result_p_o == hp && trim_n_o == hn && trim_p_o == hp,
        "R9 hold after done", {result_n_o, result_p_o}, {hn, hp});
    chk(amp_en_o && user_trim_o && err_o == exp_err, "R9 amp stays on",
        {amp_en_o, user_trim_o, err_o}, {2'b11, exp_err});
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_sim();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs during reset
    chk({amp_en_o, user_trim_o, cal_on_o, ref_sel_o, busy_o, done_o, err_o} == '0,
        "R1 control outputs", {amp_en_o, user_trim_o, cal_on_o, ref_sel_o, busy_o, done_o, err_o}, 0);
    chk({trim_n_o, trim_p_o, result_n_o, result_p_o} == '0, "R1 codes",
        {trim_n_o, trim_p_o, result_n_o, result_p_o}, 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk(!busy_o && !cal_on_o && result_n_o == '0, "R1 idle after reset",
           {busy_o, cal_on_o, result_n_o}, 0);
    for (int t = 0; t <= TOP + 1; t++) run_cal(t, 7, 0);
    for (int t = 0; t <= TOP + 1; t++) run_cal(12, t, 0);
    run_cal(TOP + 1, TOP + 1, 0);
    run_cal(0, 0, 0);
    run_cal(9, 20, 5);
    run_cal(TOP, 3, 40);
    finish_sim();
  end
endmodule